// File: doc/BRIEF.md
# PCI Target Response Policy Controller

This block makes the per-cycle response decision for the target side of a PCI port. When a new incoming cycle is presented, it looks at the bus command, at a status line that says whether the outbound master write buffers still hold data, and at a software-programmed control byte. From these it decides whether the cycle is accepted, answered with retry, or accepted and then target-disconnected together with its first data transfer. For the same cycle it also states how many 32-bit words a read fetches from the local side, whether a write is posted into the target write buffers, and whether a write is burst onto the local bus.

The control byte is written through a simple strobe-and-data port and can be read back at any time. The decision is registered, so it appears one clock after the cycle is presented. The block moves no data. A neighbouring data-path block acts on its outputs.

Top module: `pci_tgt_policy`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'h00 and `resp_vld` is 0.
- R2: A clock edge with `cfg_wr` high loads the control byte, and `cfg_rdata` shows it from the next cycle. The bit map is: bit 1 single-write, bit 2 single-read, bit 3 retry-while-busy, bit 4 write-buffer enable, bit 5 line-read enable, bit 6 burst enable. Bits 7 and 0 always read 0, whatever was written to them.
- R3: Command codes are classified as follows. Reads are 4'h2, 4'h6, 4'hA, 4'hC and 4'hE. Writes are 4'h3, 4'h7, 4'hB and 4'hF. When `cyc_valid` is high for a read or write at a clock edge, `resp_vld` is 1 in the following cycle and carries the decision for that cycle. When `cyc_valid` is low, or the command is any other code, `resp_vld` is 0 in the following cycle.
- R4: When bit 3 is 1 and `mst_wbuf_busy` is 1, `resp_code` is 2'b01 (retry) for both reads and writes.
- R5: When bit 3 is 0, cycles are not retried even when `mst_wbuf_busy` is 1. The decision is the same as with `mst_wbuf_busy` at 0.
- R6: When bit 1 is 1, a write that is not retried gets `resp_code` 2'b10 (disconnect with first data). When bit 1 is 0, it gets 2'b00 (accept). Bit 1 has no effect on reads.
- R7: When bit 2 is 1, a read that is not retried gets `resp_code` 2'b10. When bit 2 is 0, it gets 2'b00. Bit 2 has no effect on writes.
- R8: Retry takes priority over disconnect. A retried cycle also has `rd_words` 0, `wr_post` 0 and `lb_burst` 0.
- R9: For a read that is not retried, `rd_words` is 8 (a full line of 32-bit words) when bit 5 is 1, or when the command is 4'hC or 4'hE. Otherwise `rd_words` is 1. For writes, `rd_words` is 0.
- R10: For a write that is not retried, `wr_post` equals bit 4. For reads, `wr_post` is 0.
- R11: `lb_burst` is 1 only for a non-retried write with command 4'hF while bit 6 is 1. It is 0 for every other write and for every read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte readback |
| cyc_valid | input | 1 | A new incoming cycle is presented |
| cyc_cmd | input | 4 | Bus command of the presented cycle |
| mst_wbuf_busy | input | 1 | Outbound master write buffers hold data |
| resp_vld | output | 1 | Decision valid (one cycle after the cycle is presented) |
| resp_code | output | 2 | 00 accept, 01 retry, 10 disconnect with first data |
| rd_words | output | 4 | Words to fetch for a read (0, 1 or line size) |
| wr_post | output | 1 | Write is posted into the target write buffers |
| lb_burst | output | 1 | Write is burst on the local bus |

## Verification
Random control bytes are combined with random commands drawn from all sixteen codes and with the busy status both high and low. This separates the read and write single-transfer paths, the line-fetch commands from plain reads, and write-and-invalidate from other writes. Directed cases set retry-while-busy together with both single-transfer bits, to show that retry wins and suppresses every fetch or post. They also clear retry-while-busy with the buffers busy, to show that the decision does not change. Writes of 8'hFF and idle cycles check that the reserved bits read 0 and that no decision appears without a cycle.

// File: rtl/pcitp_pkg.sv
package pcitp_pkg;

  typedef enum logic [1:0] {
    RSP_ACCEPT = 2'b00,
    RSP_RETRY  = 2'b01,
    RSP_DISC   = 2'b10
  } rsp_e;

  // control byte bits 6..1, listed from bit 6 down to bit 1
  typedef struct packed {
    logic burst_en;    // bit 6
    logic line_rd;     // bit 5
    logic wbuf_en;     // bit 4
    logic retry_busy;  // bit 3
    logic sgl_rd;      // bit 2
    logic sgl_wr;      // bit 1
  } ctrl_t;

  typedef struct packed {
    logic is_rd;
    logic is_wr;
    logic line_cmd;  // read multiple / read line
    logic mwi;       // write and invalidate
  } cls_t;

endpackage

// File: rtl/pcitp_ctrl_reg.sv
module pcitp_ctrl_reg
  import pcitp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output ctrl_t       ctrl,
  output logic [7:0]  rdata
);

  localparam logic [7:0] LIVE_MASK = 8'h7E;

  logic [7:0] masked;
  ctrl_t      ctrl_d;
  ctrl_t      ctrl_q;

  assign masked = wdata & LIVE_MASK;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = ctrl_t'(masked[6:1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign rdata = {1'b0, ctrl_q, 1'b0};

endmodule

// File: rtl/pcitp_cmd_decode.sv
module pcitp_cmd_decode
  import pcitp_pkg::*;
(
  input  logic [3:0] cmd,
  output cls_t       cls
);

  always_comb begin
    cls = '0;
    unique case (cmd)
      4'h2, 4'h6, 4'hA: cls.is_rd = 1'b1;
      4'hC, 4'hE: begin
        cls.is_rd    = 1'b1;
        cls.line_cmd = 1'b1;
      end
      4'h3, 4'h7, 4'hB: cls.is_wr = 1'b1;
      4'hF: begin
        cls.is_wr = 1'b1;
        cls.mwi   = 1'b1;
      end
      default: cls = '0;
    endcase
  end

endmodule

// File: rtl/pcitp_decide.sv
module pcitp_decide
  import pcitp_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  parameter int LEN_W      = $clog2(LINE_WORDS + 1)
)(
  input  ctrl_t             ctrl,
  input  cls_t              cls,
  input  logic              busy,
  output logic              take,
  output rsp_e              code,
  output logic [LEN_W-1:0]  words,
  output logic              post,
  output logic              burst
);

  localparam logic [LEN_W-1:0] ONE_WORD  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LINE_SIZE = LEN_W'(LINE_WORDS);

  logic retry;
  logic disc;

  always_comb begin
    take  = cls.is_rd | cls.is_wr;
    retry = ctrl.retry_busy & busy;
    disc  = (cls.is_rd & ctrl.sgl_rd) | (cls.is_wr & ctrl.sgl_wr);

    code  = RSP_ACCEPT;
    words = '0;
    post  = 1'b0;
    burst = 1'b0;

    if (retry) begin
      code = RSP_RETRY;
    end else begin
      if (disc) begin
        code = RSP_DISC;
      end
      if (cls.is_rd) begin
        words = (ctrl.line_rd | cls.line_cmd) ? LINE_SIZE : ONE_WORD;
      end
      if (cls.is_wr) begin
        post  = ctrl.wbuf_en;
        burst = cls.mwi & ctrl.burst_en;
      end
    end
  end

endmodule

// File: rtl/pci_tgt_policy.sv
module pci_tgt_policy
  import pcitp_pkg::*;
#(
  parameter int LINE_WORDS = 8,
  parameter int LEN_W      = $clog2(LINE_WORDS + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              cyc_valid,
  input  logic [3:0]        cyc_cmd,
  input  logic              mst_wbuf_busy,
  output logic              resp_vld,
  output logic [1:0]        resp_code,
  output logic [LEN_W-1:0]  rd_words,
  output logic              wr_post,
  output logic              lb_burst
);

  ctrl_t             ctrl;
  cls_t              cls;
  logic              take;
  rsp_e              code_n;
  logic [LEN_W-1:0]  words_n;
  logic              post_n;
  logic              burst_n;

  logic              vld_d, vld_q;
  logic              load;
  rsp_e              code_q;
  logic [LEN_W-1:0]  words_q;
  logic              post_q;
  logic              burst_q;

  pcitp_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .wdata (cfg_wdata),
    .ctrl  (ctrl),
    .rdata (cfg_rdata)
  );

  pcitp_cmd_decode u_dec (
    .cmd (cyc_cmd),
    .cls (cls)
  );

  pcitp_decide #(
    .LINE_WORDS (LINE_WORDS),
    .LEN_W      (LEN_W)
  ) u_decide (
    .ctrl  (ctrl),
    .cls   (cls),
    .busy  (mst_wbuf_busy),
    .take  (take),
    .code  (code_n),
    .words (words_n),
    .post  (post_n),
    .burst (burst_n)
  );

  always_comb begin
    load  = cyc_valid & take;
    vld_d = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= RSP_ACCEPT;
      words_q <= '0;
      post_q  <= 1'b0;
      burst_q <= 1'b0;
    end else if (load) begin
      code_q  <= code_n;
      words_q <= words_n;
      post_q  <= post_n;
      burst_q <= burst_n;
    end
  end

  assign resp_vld  = vld_q;
  assign resp_code = code_q;
  assign rd_words  = words_q;
  assign wr_post   = post_q;
  assign lb_burst  = burst_q;

endmodule

// File: rtl/pcitp_policy_chk.sv
module pcitp_policy_chk #(
  parameter int LINE_WORDS = 8,
  parameter int LEN_W      = $clog2(LINE_WORDS + 1)
)(
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        cfg_rdata,
  input logic              cyc_valid,
  input logic [3:0]        cyc_cmd,
  input logic              mst_wbuf_busy,
  input logic              resp_vld,
  input logic [1:0]        resp_code,
  input logic [LEN_W-1:0]  rd_words,
  input logic              wr_post,
  input logic              lb_burst
);

  logic rw_cmd;
  assign rw_cmd = (cyc_cmd == 4'h2) || (cyc_cmd == 4'h6) || (cyc_cmd == 4'hA) ||
                  (cyc_cmd == 4'hC) || (cyc_cmd == 4'hE) || (cyc_cmd == 4'h3) ||
                  (cyc_cmd == 4'h7) || (cyc_cmd == 4'hB) || (cyc_cmd == 4'hF);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[7] == 1'b0) && (cfg_rdata[0] == 1'b0));

  p_idle_no_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> !resp_vld);

  p_retry_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && rw_cmd && cfg_rdata[3] && mst_wbuf_busy) |=> (resp_vld && resp_code == 2'b01));

  p_retry_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && resp_code == 2'b01) |-> (rd_words == '0 && !wr_post && !lb_burst));

  p_read_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_vld && rd_words != '0) |-> (rd_words == LEN_W'(1) || rd_words == LEN_W'(LINE_WORDS)));

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld |-> (resp_code != 2'b11));

endmodule

bind pci_tgt_policy pcitp_policy_chk #(
  .LINE_WORDS (LINE_WORDS),
  .LEN_W      (LEN_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_rdata     (cfg_rdata),
  .cyc_valid     (cyc_valid),
  .cyc_cmd       (cyc_cmd),
  .mst_wbuf_busy (mst_wbuf_busy),
  .resp_vld      (resp_vld),
  .resp_code     (resp_code),
  .rd_words      (rd_words),
  .wr_post       (wr_post),
  .lb_burst      (lb_burst)
);

// File: tb/sim_pci_tgt_policy.sv
`timescale 1ns/1ps
module sim_pci_tgt_policy;

  logic       clk;
  logic       rst_n;
  logic       cfg_wr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       cyc_valid;
  logic [3:0] cyc_cmd;
  logic       mst_wbuf_busy;
  logic       resp_vld;
  logic [1:0] resp_code;
  logic [3:0] rd_words;
  logic       wr_post;
  logic       lb_burst;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_ctrl;
  bit done = 0;

  pci_tgt_policy u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid), .cyc_cmd(cyc_cmd),
    .mst_wbuf_busy(mst_wbuf_busy), .resp_vld(resp_vld), .resp_code(resp_code),
    .rd_words(rd_words), .wr_post(wr_post), .lb_burst(lb_burst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected {vld, code[1:0], words[3:0], post, burst}
  function automatic logic [8:0] expect_of(input logic [7:0] c, input logic [3:0] cmd,
                                           input logic busy);
    logic rd, wr, line, mwi, rty;
    logic [1:0] code;
    logic [3:0] words;
    logic post, burst;
    rd   = (cmd == 4'h2) || (cmd == 4'h6) || (cmd == 4'hA) || (cmd == 4'hC) || (cmd == 4'hE);
    wr   = (cmd == 4'h3) || (cmd == 4'h7) || (cmd == 4'hB) || (cmd == 4'hF);
    line = (cmd == 4'hC) || (cmd == 4'hE);
    mwi  = (cmd == 4'hF);
    rty  = c[3] && busy;
    code = 2'b00; words = 4'd0; post = 1'b0; burst = 1'b0;
    if (rty) code = 2'b01;
    else begin
      if ((rd && c[2]) || (wr && c[1])) code = 2'b10;
      if (rd) words = (c[5] || line) ? 4'd8 : 4'd1;
      if (wr) begin post = c[4]; burst = mwi && c[6]; end
    end
    return {rd || wr, code, words, post, burst};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = b;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_ctrl = b & 8'h7E;
    chk("R2 readback", {24'd0, cfg_rdata}, {24'd0, model_ctrl});
  endtask

  task automatic run_cyc(input logic [3:0] cmd, input logic busy, input string req);
    logic [8:0] e;
    e = expect_of(model_ctrl, cmd, busy);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_cmd = cmd; mst_wbuf_busy = busy;
    @(negedge clk);
    cyc_valid = 1'b0;
    chk({req, " R3 vld"}, {31'd0, resp_vld}, {31'd0, e[8]});
    if (e[8]) begin
      chk({req, " R4/R6/R7/R8 code"}, {30'd0, resp_code}, {30'd0, e[7:6]});
      chk({req, " R9 words"}, {28'd0, rd_words}, {28'd0, e[5:2]});
      chk({req, " R10 post"}, {31'd0, wr_post}, {31'd0, e[1]});
      chk({req, " R11 burst"}, {31'd0, lb_burst}, {31'd0, e[0]});
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = 8'h00; cyc_valid = 1'b0;
    cyc_cmd = 4'h0; mst_wbuf_busy = 1'b0; model_ctrl = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", {24'd0, cfg_rdata}, 32'h0);
    chk("R1 vld", {31'd0, resp_vld}, 32'h0);

    // reserved bits
    wr_ctrl(8'hFF);
    wr_ctrl(8'h81);

    // retry beats disconnect
    wr_ctrl(8'h0E);
    run_cyc(4'h6, 1'b1, "R8 read");
    run_cyc(4'h7, 1'b1, "R8 write");
    run_cyc(4'h7, 1'b0, "R6 write");
    run_cyc(4'h6, 1'b0, "R7 read");
    // busy but retry off
    wr_ctrl(8'h70);
    run_cyc(4'h6, 1'b1, "R5 read");
    run_cyc(4'hF, 1'b1, "R5 mwi");
    run_cyc(4'h7, 1'b1, "R5 write");
    // line commands without line enable
    wr_ctrl(8'h00);
    run_cyc(4'hC, 1'b0, "R9 mrm");
    run_cyc(4'hE, 1'b0, "R9 mrl");
    run_cyc(4'h6, 1'b0, "R9 plain");
    run_cyc(4'hF, 1'b0, "R11 mwi off");
    run_cyc(4'h0, 1'b0, "R3 other");
    // single read only: writes unaffected
    wr_ctrl(8'h04);
    run_cyc(4'h3, 1'b0, "R7 write unaffected");
    wr_ctrl(8'h02);
    run_cyc(4'hA, 1'b0, "R6 read unaffected");

    for (int i = 0; i < 1500; i++) begin
      if ((i % 7) == 0) wr_ctrl(8'($urandom));
      run_cyc(4'($urandom), 1'($urandom), "rand");
      if ((i % 11) == 0) begin
        @(negedge clk);
        chk("R3 idle", {31'd0, resp_vld}, 32'h0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule